// File: doc/BRIEF.md
# MSI Snooping Cache Line Controller

This block keeps coherence for a small direct-mapped write-back cache that shares a snooping bus with other caches. Each line holds one data word, an address tag and one of three states: Modified (the only current copy, memory is stale), Shared (current, and memory and other caches may hold the same value) or Invalid. The processor side presents a read or a write and holds it until a one-cycle done pulse. Accesses that the line can serve by itself complete without touching the bus. Misses, upgrades and conflict evictions request the bus, wait for a grant and then drive a read, a read-for-ownership or a write-back.

At the same time the block watches the transactions that other caches place on the bus. A snooped read for a line held Modified makes the block supply its word on a flush port and drop the line to Shared. A snooped read-for-ownership invalidates any held copy, and a Modified copy is flushed first. A snoop always wins over the processor side: in a cycle with a snoop, no processor request advances and no bus transaction is driven.

The address is split into a line index (low bits) and a tag (high bits). The bus command is a 2-bit code: 0 none, 1 read (BusRd), 2 read-for-ownership (BusRdEx), 3 write-back (BusWr).

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and bus_req, bus_cmd, cpu_done and snp_flush are all 0; cpu_done is a single-cycle pulse.
- R2: A read to an Invalid or tag-mismatched line raises bus_req, drives bus_cmd=1 with the request address in the first cycle with bus_gnt and no snoop, loads bus_rdata into the line as Shared, and pulses cpu_done with cpu_rdata=bus_rdata in the next cycle.
- R3: A write to a line that is not Modified for that address (Invalid, Shared or tag mismatch) drives bus_cmd=2 with the request address once granted, and leaves the line Modified holding the write data.
- R4: A read to a Shared or Modified line with matching tag, or a write to a Modified line with matching tag, raises no bus_req and pulses cpu_done in the cycle after the request is accepted; a write hit updates the word, and cpu_rdata returns the line's word after the operation.
- R5: bus_cmd is non-zero only in a cycle where bus_req and bus_gnt are both 1.
- R6: A miss whose indexed line is Modified with another tag first drives bus_cmd=3 with the victim's address and word, then the fill transaction for the new address; the victim's data is lost from the cache.
- R7: A snooped read (snp_cmd=1) to a line held Modified with a matching tag pulses snp_flush in the next cycle with snp_flush_data equal to the line's word, and the line becomes Shared.
- R8: A snooped read-for-ownership (snp_cmd=2) to a held line makes it Invalid; if it was Modified, snp_flush pulses in the next cycle with its word, if Shared no flush occurs.
- R9: A snoop to an Invalid line, to a tag mismatch, a snooped write-back (snp_cmd=3), or a snooped read to a Shared line changes no line state and raises no flush.
- R10: In any cycle with snp_valid=1, bus_cmd is 0 and no processor request completes; the pending request proceeds in the following cycles.
- R11: If a victim awaiting its write-back grant leaves the Modified state through a snoop, the write-back is dropped and only the fill transaction is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present, held until cpu_done |
| cpu_req_write | input | 1 | 1 for a write, 0 for a read |
| cpu_req_addr | input | ADDR_W | Request address; low bits index, high bits tag |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Line word after the completed operation |
| bus_req | output | 1 | Request for bus ownership |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_cmd | output | 2 | Driven transaction: 0 none, 1 read, 2 read-for-ownership, 3 write-back |
| bus_addr | output | ADDR_W | Address of the driven transaction |
| bus_wdata | output | DATA_W | Word written back by a write-back |
| bus_rdata | input | DATA_W | Fill word, sampled in the cycle of a read or read-for-ownership |
| snp_valid | input | 1 | Another cache drives a transaction this cycle |
| snp_cmd | input | 2 | Snooped command, same code as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | One-cycle pulse: this cache supplies its Modified word |
| snp_flush_data | output | DATA_W | Word supplied with snp_flush |

## Verification
The two functions that can share a cycle are snoop handling and progress of a pending processor request. The bench parks a read miss in its bus-request wait with the grant held off, then raises the grant together with a snoop and judges that no command appears in that cycle and the read is driven one cycle later. The same collision is staged on a local hit, where done must slip by one cycle, and on a victim waiting for its write-back, where a snooped read must turn the write-back into nothing while the flush carries the victim's word.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_I = 2'd0,
    LS_S = 2'd1,
    LS_M = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    BC_NONE = 2'd0,
    BC_RD   = 2'd1,
    BC_RDX  = 2'd2,
    BC_WB   = 2'd3
  } bus_cmd_e;

  // Can the access finish without the bus, given a matching tag?
  function automatic logic serves_locally(logic is_wr, line_st_e st);
    return is_wr ? (st == LS_M) : (st != LS_I);
  endfunction

  // State a line takes after its own fill.
  function automatic line_st_e fill_state(logic is_wr);
    return is_wr ? LS_M : LS_S;
  endfunction

  // State a held line takes after a foreign transaction.
  function automatic line_st_e snoop_next(line_st_e st, bus_cmd_e c);
    line_st_e r;
    r = st;
    if (c == BC_RDX) r = LS_I;
    else if (c == BC_RD && st == LS_M) r = LS_S;
    return r;
  endfunction

  // Must this cache hand its word out for a foreign transaction?
  function automatic logic snoop_supplies(line_st_e st, bus_cmd_e c);
    return (st == LS_M) && ((c == BC_RD) || (c == BC_RDX));
  endfunction

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  prc_idx,
  input  logic              prc_we,
  input  line_st_e          prc_st,
  input  logic [TAG_W-1:0]  prc_tag,
  input  logic [DATA_W-1:0] prc_data,
  input  logic [IDX_W-1:0]  snp_idx,
  input  logic              snp_we,
  input  line_st_e          snp_st,
  output line_st_e          rd_a_st,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_a_data,
  output line_st_e          rd_b_st,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [DATA_W-1:0] rd_b_data
);

  line_st_e          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  logic [LINES-1:0] snp_sel;
  logic [LINES-1:0] prc_sel;

  // Per-line write decode; a snoop update outranks the processor side.
  for (genvar g = 0; g < LINES; g++) begin : g_sel
    assign snp_sel[g] = snp_we && (snp_idx == IDX_W'(g));
    assign prc_sel[g] = prc_we && (prc_idx == IDX_W'(g)) && !snp_sel[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        st_q[i]   <= LS_I;
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < LINES; i++) begin
        if (snp_sel[i]) begin
          st_q[i] <= snp_st;
        end else if (prc_sel[i]) begin
          st_q[i]   <= prc_st;
          tag_q[i]  <= prc_tag;
          data_q[i] <= prc_data;
        end
      end
    end
  end

  assign rd_a_st   = st_q[prc_idx];
  assign rd_a_tag  = tag_q[prc_idx];
  assign rd_a_data = data_q[prc_idx];
  assign rd_b_st   = st_q[snp_idx];
  assign rd_b_tag  = tag_q[snp_idx];
  assign rd_b_data = data_q[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  bus_cmd_e          snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  line_st_e          rd_st,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  snp_idx,
  output logic              snp_we,
  output line_st_e          snp_st,
  output logic              ev_snp_held,
  output logic              ev_snp_flush,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_flush_data
);

  logic [TAG_W-1:0] snp_tag;

  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  assign ev_snp_held  = snp_valid && (rd_st != LS_I) && (rd_tag == snp_tag);
  assign snp_st       = snoop_next(rd_st, snp_cmd);
  assign snp_we       = ev_snp_held && (snp_st != rd_st);
  assign ev_snp_flush = ev_snp_held && snoop_supplies(rd_st, snp_cmd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snp_flush      <= 1'b0;
      snp_flush_data <= '0;
    end else begin
      snp_flush <= ev_snp_flush;
      if (ev_snp_flush) snp_flush_data <= rd_data;
    end
  end

endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
  import msi_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              snp_valid,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output bus_cmd_e          bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  line_st_e          rd_st,
  input  logic [TAG_W-1:0]  rd_tag,
  input  logic [DATA_W-1:0] rd_data,
  output logic [IDX_W-1:0]  prc_idx,
  output logic              prc_we,
  output line_st_e          prc_st,
  output logic [TAG_W-1:0]  prc_tag,
  output logic [DATA_W-1:0] prc_data,
  output logic              ev_local_hit,
  output logic              ev_wb_drop
);

  typedef enum logic [1:0] {
    P_IDLE = 2'd0,
    P_WB   = 2'd1,
    P_FILL = 2'd2,
    P_RESP = 2'd3
  } pst_e;

  pst_e st_q, st_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  logic [TAG_W-1:0] req_tag;
  logic tag_match, hit, victim_dirty, go;

  assign prc_idx      = cpu_req_addr[IDX_W-1:0];
  assign req_tag      = cpu_req_addr[ADDR_W-1:IDX_W];
  assign tag_match    = (rd_st != LS_I) && (rd_tag == req_tag);
  assign hit          = tag_match && serves_locally(cpu_req_write, rd_st);
  assign victim_dirty = (rd_st == LS_M) && (rd_tag != req_tag);
  assign go           = !snp_valid;

  always_comb begin
    st_d         = st_q;
    rdata_d      = rdata_q;
    bus_req      = 1'b0;
    bus_cmd      = BC_NONE;
    bus_addr     = '0;
    bus_wdata    = '0;
    prc_we       = 1'b0;
    prc_st       = rd_st;
    prc_tag      = rd_tag;
    prc_data     = rd_data;
    ev_local_hit = 1'b0;
    ev_wb_drop   = 1'b0;
    unique case (st_q)
      P_IDLE: begin
        if (cpu_req_valid && go) begin
          if (hit) begin
            ev_local_hit = 1'b1;
            prc_we       = cpu_req_write;
            prc_st       = LS_M;
            prc_tag      = req_tag;
            prc_data     = cpu_req_wdata;
            rdata_d      = cpu_req_write ? cpu_req_wdata : rd_data;
            st_d         = P_RESP;
          end else if (victim_dirty) begin
            st_d = P_WB;
          end else begin
            st_d = P_FILL;
          end
        end
      end
      P_WB: begin
        if (!victim_dirty) begin
          ev_wb_drop = 1'b1;
          st_d       = P_FILL;
        end else begin
          bus_req = 1'b1;
          if (bus_gnt && go) begin
            bus_cmd   = BC_WB;
            bus_addr  = {rd_tag, prc_idx};
            bus_wdata = rd_data;
            prc_we    = 1'b1;
            prc_st    = LS_I;
            st_d      = P_FILL;
          end
        end
      end
      P_FILL: begin
        bus_req = 1'b1;
        if (bus_gnt && go) begin
          bus_cmd  = cpu_req_write ? BC_RDX : BC_RD;
          bus_addr = cpu_req_addr;
          prc_we   = 1'b1;
          prc_st   = fill_state(cpu_req_write);
          prc_tag  = req_tag;
          prc_data = cpu_req_write ? cpu_req_wdata : bus_rdata;
          rdata_d  = cpu_req_write ? cpu_req_wdata : bus_rdata;
          st_d     = P_RESP;
        end
      end
      P_RESP: begin
        st_d = P_IDLE;
      end
      default: st_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= P_IDLE;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
    end
  end

  assign cpu_done  = (st_q == P_RESP);
  assign cpu_rdata = rdata_q;

endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_flush_data
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  prc_idx, snp_idx;
  logic              prc_we, snp_we;
  line_st_e          prc_st, snp_st;
  logic [TAG_W-1:0]  prc_tag;
  logic [DATA_W-1:0] prc_data;
  line_st_e          rd_a_st, rd_b_st;
  logic [TAG_W-1:0]  rd_a_tag, rd_b_tag;
  logic [DATA_W-1:0] rd_a_data, rd_b_data;
  bus_cmd_e          cmd_w;

  // Named internal events for the checker.
  logic ev_local_hit, ev_wb_drop, ev_snp_held, ev_snp_flush;

  msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .prc_idx(prc_idx), .prc_we(prc_we), .prc_st(prc_st),
    .prc_tag(prc_tag), .prc_data(prc_data),
    .snp_idx(snp_idx), .snp_we(snp_we), .snp_st(snp_st),
    .rd_a_st(rd_a_st), .rd_a_tag(rd_a_tag), .rd_a_data(rd_a_data),
    .rd_b_st(rd_b_st), .rd_b_tag(rd_b_tag), .rd_b_data(rd_b_data)
  );

  msi_snoop_unit #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_cmd(bus_cmd_e'(snp_cmd)), .snp_addr(snp_addr),
    .rd_st(rd_b_st), .rd_tag(rd_b_tag), .rd_data(rd_b_data),
    .snp_idx(snp_idx), .snp_we(snp_we), .snp_st(snp_st),
    .ev_snp_held(ev_snp_held), .ev_snp_flush(ev_snp_flush),
    .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
  );

  msi_proc_fsm #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid), .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .bus_req(bus_req), .bus_cmd(cmd_w), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_st(rd_a_st), .rd_tag(rd_a_tag), .rd_data(rd_a_data),
    .prc_idx(prc_idx), .prc_we(prc_we), .prc_st(prc_st),
    .prc_tag(prc_tag), .prc_data(prc_data),
    .ev_local_hit(ev_local_hit), .ev_wb_drop(ev_wb_drop)
  );

  assign bus_cmd = cmd_w;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_req,
  input logic       bus_gnt,
  input logic [1:0] bus_cmd,
  input logic       snp_valid,
  input logic       cpu_done,
  input logic       snp_flush,
  input logic       ev_local_hit,
  input logic       ev_wb_drop,
  input logic       ev_snp_flush
);

  // R5
  cmd_needs_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd != 2'd0) |-> (bus_req && bus_gnt));

  // R10
  snoop_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (bus_cmd == 2'd0));

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  // R4
  local_hit_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_local_hit |=> cpu_done);

  // R2
  fill_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_cmd == 2'd1) || (bus_cmd == 2'd2)) |=> cpu_done);

  // R7
  flush_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_snp_flush |=> snp_flush);

  // R9
  flush_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> $past(snp_valid));

  // R11
  wb_drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_drop |-> (bus_cmd == 2'd0));

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .bus_cmd(bus_cmd), .snp_valid(snp_valid), .cpu_done(cpu_done),
  .snp_flush(snp_flush), .ev_local_hit(ev_local_hit),
  .ev_wb_drop(ev_wb_drop), .ev_snp_flush(ev_snp_flush)
);

// File: tb/sim_msi_snoop_ctrl.sv
module sim_msi_snoop_ctrl;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req, bus_gnt;
  logic gnt_en = 1'b1;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic snp_valid = 1'b0;
  logic [1:0] snp_cmd = 2'd0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_flush;
  logic [DATA_W-1:0] snp_flush_data;

  int checks = 0;
  int failures = 0;
  bit done_flag = 1'b0;

  // Bus log
  logic [1:0]        lg_cmd  [8];
  logic [ADDR_W-1:0] lg_addr [8];
  logic [DATA_W-1:0] lg_data [8];
  int log_n = 0;

  always #(CLK_P/2) clk = ~clk;

  // Memory model: word returned for an address.
  function automatic logic [DATA_W-1:0] memw(logic [ADDR_W-1:0] a);
    return {a, ~a};
  endfunction

  assign bus_rdata = memw(bus_addr);
  assign bus_gnt   = bus_req & gnt_en;

  msi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(4)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_write(cpu_req_write),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
  );

  always @(negedge clk) begin
    #1;
    if (rst_n && bus_cmd != 2'd0) begin
      if (log_n < 8) begin
        lg_cmd[log_n]  = bus_cmd;
        lg_addr[log_n] = bus_addr;
        lg_data[log_n] = bus_wdata;
      end
      log_n++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] wd, output logic [DATA_W-1:0] rd,
                       output int cyc);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = wd;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 50);
    rd = cpu_rdata;
    cpu_req_valid = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [ADDR_W-1:0] a,
                       output bit fl, output logic [DATA_W-1:0] fd);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    fl = snp_flush; fd = snp_flush_data;
    snp_valid = 1'b0;
  endtask

  task automatic t_reset();
    check(bus_req == 1'b0, "R1 bus_req", 32'(bus_req), 0);
    check(bus_cmd == 2'd0, "R1 bus_cmd", 32'(bus_cmd), 0);
    check(cpu_done == 1'b0, "R1 cpu_done", 32'(cpu_done), 0);
    check(snp_flush == 1'b0, "R1 snp_flush", 32'(snp_flush), 0);
  endtask

  task automatic t_read_miss_hit();
    logic [DATA_W-1:0] rd; int cyc;
    log_n = 0;
    do_op(1'b0, 8'h11, '0, rd, cyc);
    check(log_n == 1 && lg_cmd[0] == 2'd1 && lg_addr[0] == 8'h11, "R2 read miss BusRd",
          32'(lg_cmd[0]), 1);
    check(rd == memw(8'h11), "R2 fill data", 32'(rd), 32'(memw(8'h11)));
    check(cyc == 2, "R2 miss latency", 32'(cyc), 2);
    log_n = 0;
    do_op(1'b0, 8'h11, '0, rd, cyc);
    check(log_n == 0, "R4 read hit shared no bus", 32'(log_n), 0);
    check(rd == memw(8'h11) && cyc == 1, "R4 read hit data/latency", 32'(rd), 32'(memw(8'h11)));
  endtask

  task automatic t_writes();
    logic [DATA_W-1:0] rd; int cyc;
    log_n = 0;
    do_op(1'b1, 8'h11, 16'hBEEF, rd, cyc);
    check(log_n == 1 && lg_cmd[0] == 2'd2 && lg_addr[0] == 8'h11, "R3 upgrade from S",
          32'(lg_cmd[0]), 2);
    log_n = 0;
    do_op(1'b1, 8'h11, 16'h1234, rd, cyc);
    check(log_n == 0 && cyc == 1, "R4 write hit modified", 32'(log_n), 0);
    do_op(1'b0, 8'h11, '0, rd, cyc);
    check(rd == 16'h1234 && log_n == 0, "R4 read after write hit", 32'(rd), 32'h1234);
    log_n = 0;
    do_op(1'b1, 8'h22, 16'hCAFE, rd, cyc);
    check(log_n == 1 && lg_cmd[0] == 2'd2 && lg_addr[0] == 8'h22, "R3 write miss invalid",
          32'(lg_cmd[0]), 2);
    do_op(1'b0, 8'h22, '0, rd, cyc);
    check(rd == 16'hCAFE, "R3 written word held", 32'(rd), 32'hCAFE);
  endtask

  task automatic t_evict();
    logic [DATA_W-1:0] rd; int cyc;
    log_n = 0;
    do_op(1'b0, 8'h32, '0, rd, cyc);
    check(log_n == 2, "R6 two transactions", 32'(log_n), 2);
    check(lg_cmd[0] == 2'd3 && lg_addr[0] == 8'h22 && lg_data[0] == 16'hCAFE,
          "R6 write-back first", 32'(lg_data[0]), 32'hCAFE);
    check(lg_cmd[1] == 2'd1 && lg_addr[1] == 8'h32, "R6 fill second", 32'(lg_addr[1]), 32'h32);
    check(rd == memw(8'h32) && cyc == 3, "R6 evict data/latency", 32'(cyc), 3);
  endtask

  task automatic t_snoop_read();
    bit fl; logic [DATA_W-1:0] fd, rd; int cyc;
    snoop(2'd1, 8'h11, fl, fd);
    check(fl == 1'b1 && fd == 16'h1234, "R7 flush on snooped read", 32'(fd), 32'h1234);
    log_n = 0;
    do_op(1'b0, 8'h11, '0, rd, cyc);
    check(log_n == 0 && rd == 16'h1234, "R7 still readable as shared", 32'(log_n), 0);
    do_op(1'b1, 8'h11, 16'h5555, rd, cyc);
    check(log_n == 1 && lg_cmd[0] == 2'd2, "R7 line became shared", 32'(lg_cmd[0]), 2);
  endtask

  task automatic t_snoop_rdx();
    bit fl; logic [DATA_W-1:0] fd, rd; int cyc;
    snoop(2'd2, 8'h11, fl, fd);
    check(fl == 1'b1 && fd == 16'h5555, "R8 flush modified on rdx", 32'(fd), 32'h5555);
    log_n = 0;
    do_op(1'b0, 8'h11, '0, rd, cyc);
    check(log_n == 1 && lg_cmd[0] == 2'd1, "R8 modified invalidated", 32'(lg_cmd[0]), 1);
    snoop(2'd2, 8'h32, fl, fd);
    check(fl == 1'b0, "R8 shared no flush", 32'(fl), 0);
    log_n = 0;
    do_op(1'b0, 8'h32, '0, rd, cyc);
    check(log_n == 1 && lg_cmd[0] == 2'd1, "R8 shared invalidated", 32'(lg_cmd[0]), 1);
  endtask

  task automatic t_snoop_ignore();
    bit fl; logic [DATA_W-1:0] fd, rd; int cyc;
    // 0x11 is Shared here
    snoop(2'd2, 8'h15, fl, fd);
    check(fl == 1'b0, "R9 tag mismatch no flush", 32'(fl), 0);
    snoop(2'd3, 8'h11, fl, fd);
    check(fl == 1'b0, "R9 write-back snoop no flush", 32'(fl), 0);
    snoop(2'd1, 8'h11, fl, fd);
    check(fl == 1'b0, "R9 read on shared no flush", 32'(fl), 0);
    snoop(2'd1, 8'h23, fl, fd);
    check(fl == 1'b0, "R9 invalid line no flush", 32'(fl), 0);
    log_n = 0;
    do_op(1'b0, 8'h11, '0, rd, cyc);
    check(log_n == 0 && cyc == 1, "R9 line kept shared", 32'(log_n), 0);
  endtask

  task automatic t_priority();
    logic [DATA_W-1:0] rd; int cyc;
    gnt_en = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h03;
    log_n = 0;
    @(negedge clk);
    gnt_en = 1'b1; snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = 8'h3F;
    #1;
    check(bus_req == 1'b1 && bus_cmd == 2'd0, "R10 no command during snoop",
          32'(bus_cmd), 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #1;
    check(bus_cmd == 2'd1 && cpu_done == 1'b0, "R10 read issued after snoop",
          32'(bus_cmd), 1);
    @(negedge clk);
    check(cpu_done == 1'b1 && cpu_rdata == memw(8'h03), "R10 miss completes",
          32'(cpu_rdata), 32'(memw(8'h03)));
    cpu_req_valid = 1'b0;
    // Local hit colliding with a snoop
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_addr = 8'h03;
    snp_valid = 1'b1; snp_cmd = 2'd3; snp_addr = 8'h3E;
    cyc = 0;
    do begin
      @(negedge clk);
      snp_valid = 1'b0;
      cyc++;
    end while (!cpu_done && cyc < 20);
    rd = cpu_rdata;
    cpu_req_valid = 1'b0;
    check(cyc == 2 && rd == memw(8'h03), "R10 hit delayed one cycle", 32'(cyc), 2);
  endtask

  task automatic t_wb_drop();
    bit fl; logic [DATA_W-1:0] rd; int cyc;
    do_op(1'b1, 8'h00, 16'h7777, rd, cyc);
    gnt_en = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_addr = 8'h04;
    log_n = 0;
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = 8'h00;
    @(negedge clk);
    fl = snp_flush;
    check(fl == 1'b1 && snp_flush_data == 16'h7777, "R11 victim flushed",
          32'(snp_flush_data), 32'h7777);
    snp_valid = 1'b0; gnt_en = 1'b1;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 20);
    rd = cpu_rdata;
    cpu_req_valid = 1'b0;
    check(log_n == 1 && lg_cmd[0] == 2'd1 && lg_addr[0] == 8'h04, "R11 write-back dropped",
          32'(log_n), 1);
    check(rd == memw(8'h04), "R11 fill data", 32'(rd), 32'(memw(8'h04)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_miss_hit();
    t_writes();
    t_evict();
    t_snoop_read();
    t_snoop_rdx();
    t_snoop_ignore();
    t_priority();
    t_wb_drop();
    repeat (2) @(negedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 20000);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule